// File: doc/BRIEF.md
# UART FIFO Control and Trigger Logic

This block holds the FIFO control register of a UART and the FIFO logic behind it: transmit and receive queues of parameterised depth (64 bytes by default), each with read and write pointers and a level counter, and the two trigger interrupts. The host writes an 8-bit control word that may not be read back. A separate one-bit gate, written by the enhanced-features logic, decides whether the enhanced fields of that word take effect. The host pushes transmit bytes and the transmit shift register pops them. The receive shift register pushes bytes and the host pops them.

A write with the FIFO-enable bit set can flush either queue. The flush bits act once and are not stored, and they leave the shift registers alone. The two trigger-select fields feed one shared select, so the receive and transmit thresholds always come from the same table entry. The transmit interrupt asserts when the level falls below its threshold after it has been above it. It also asserts when the queue is empty after a reload that never rose above the threshold. When the enable bit is clear, both queues shrink to a single-byte holding register.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the FIFO enable, wake-up enable and trigger select are all 0. A control write with bit 0 at 0 changes only the enable and leaves the wake-up enable and the trigger select as they were.
- R2: A control write with bits 0 and 1 both at 1 empties the receive queue, so its count is 0 on the next cycle. The bit is not stored, and a later write without bit 1 leaves the count unchanged.
- R3: A control write with bits 0 and 2 both at 1 empties the transmit queue, so its count is 0 on the next cycle. The receive queue is not affected.
- R4: Bit 3 (wake-up interrupt enable) and bits 5:4 are taken only while the enhanced gate is 1. With the gate at 0 the wake-up enable keeps its value.
- R5: There is one shared 2-bit select. A write with bit 0 at 1 loads it from bits 5:4 when the gate is 1 and from bits 7:6 otherwise. For a depth D, codes 00/01/10/11 give receive thresholds D/8, D/4, 7D/8 and 15D/16, and transmit thresholds D/8, D/4, D/2 and 7D/8.
- R6: The receive interrupt is high exactly while the receive count is at or above the receive threshold.
- R7: Once the transmit count has been above the transmit threshold, the transmit interrupt is high whenever the count is below that threshold.
- R8: The transmit interrupt is high whenever the transmit queue is empty. After an empty queue is reloaded without ever exceeding the threshold, the interrupt stays low for any non-zero count. A flush or an emptying clears the "was above" state.
- R9: A push into a full queue is dropped, and the count never exceeds the depth.
- R10: A pop from an empty queue leaves the count at 0 and the pop data unchanged. Pop data appears on the cycle after the pop.
- R11: Any change of the enable bit empties both queues. While the enable is 0, each queue holds at most one byte, and the receive threshold is 1.
- R12: Bytes leave each queue in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Control-word write strobe |
| host_wdata | input | 8 | Control word |
| enh_wr | input | 1 | Enhanced-gate write strobe |
| enh_d | input | 1 | Enhanced-gate value |
| tx_push | input | 1 | Host pushes a transmit byte |
| tx_push_data | input | DATA_W | Transmit byte in |
| tx_pop | input | 1 | Transmit shift register takes a byte |
| tx_pop_data | output | DATA_W | Last byte taken from the transmit queue |
| rx_push | input | 1 | Receive shift register delivers a byte |
| rx_push_data | input | DATA_W | Received byte in |
| rx_pop | input | 1 | Host reads a received byte |
| rx_pop_data | output | DATA_W | Last byte read from the receive queue |
| tx_count | output | CNT_W | Transmit queue level |
| rx_count | output | CNT_W | Receive queue level |
| fifo_en | output | 1 | FIFO enable bit |
| wake_en | output | 1 | Wake-up interrupt enable |
| trig_sel | output | 2 | Shared trigger select |
| tx_irq | output | 1 | Transmit trigger interrupt |
| rx_irq | output | 1 | Receive trigger interrupt |

## Verification
The bench builds the block with DEPTH set to 16, which gives a 5-bit count. The thresholds are then 2/4/14/15 for receive and 2/4/8/14 for transmit. At this depth a full queue, the dropped push and a complete drain in order take only tens of cycles. The highest receive threshold and the transmit threshold crossings in both directions can also be driven byte by byte, and the single-byte mode and the gate paths are covered with a handful of writes.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
   localparam int CTRL_W = 8;

   function automatic int rx_level(input int depth, input logic [1:0] sel);
      case (sel)
         2'd0:    return depth / 8;
         2'd1:    return depth / 4;
         2'd2:    return (depth * 7) / 8;
         default: return (depth * 15) / 16;
      endcase
   endfunction

   function automatic int tx_level(input int depth, input logic [1:0] sel);
      case (sel)
         2'd0:    return depth / 8;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return (depth * 7) / 8;
      endcase
   endfunction
endpackage

// File: rtl/ufc_ctrl.sv
module ufc_ctrl
   import ufc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [CTRL_W-1:0] host_wdata,
   input  logic              enh_wr,
   input  logic              enh_d,
   output logic              enh_q,
   output logic              fifo_en,
   output logic              wake_en,
   output logic [1:0]        trig_sel,
   output logic              rx_flush,
   output logic              tx_flush
);
   logic en_change;

   assign en_change = host_wr && (host_wdata[0] != fifo_en);
   assign rx_flush  = en_change || (host_wr && host_wdata[0] && host_wdata[1]);
   assign tx_flush  = en_change || (host_wr && host_wdata[0] && host_wdata[2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enh_q    <= 1'b0;
         fifo_en  <= 1'b0;
         wake_en  <= 1'b0;
         trig_sel <= 2'd0;
      end else begin
         if (enh_wr) enh_q <= enh_d;
         if (host_wr) begin
            fifo_en <= host_wdata[0];
            if (host_wdata[0]) begin
               trig_sel <= enh_q ? host_wdata[5:4] : host_wdata[7:6];
               if (enh_q) wake_en <= host_wdata[3];
            end
         end
      end
   end
endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [CNT_W-1:0]  cap,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  count
);
   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign do_push = push && (count < cap) && !flush;
   assign do_pop  = pop && (count != '0) && !flush;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         pop_data <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop) begin
            rd_ptr   <= rd_ptr + 1'b1;
            pop_data <= mem[rd_ptr];
         end
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/ufc_trig.sv
module ufc_trig
   import ufc_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic [1:0]       trig_sel,
   input  logic             tx_flush,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   output logic             tx_irq,
   output logic             rx_irq
);
   logic [CNT_W-1:0] rx_tab [4];
   logic [CNT_W-1:0] tx_tab [4];
   logic [CNT_W-1:0] rx_lvl, tx_lvl;
   logic             above_q;

   for (genvar i = 0; i < 4; i++) begin : g_tab
      assign rx_tab[i] = CNT_W'(rx_level(DEPTH, 2'(i)));
      assign tx_tab[i] = CNT_W'(tx_level(DEPTH, 2'(i)));
   end

   assign rx_lvl = fifo_en ? rx_tab[trig_sel] : CNT_W'(1);
   assign tx_lvl = fifo_en ? tx_tab[trig_sel] : CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          above_q <= 1'b0;
      else if (tx_flush || tx_count == '0) above_q <= 1'b0;
      else if (tx_count > tx_lvl)          above_q <= 1'b1;
   end

   assign rx_irq = rx_count >= rx_lvl;
   assign tx_irq = above_q ? (tx_count < tx_lvl) : (tx_count == '0);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
   import ufc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   input  logic              enh_wr,
   input  logic              enh_d,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_push_data,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_pop_data,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_push_data,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_pop_data,
   output logic [CNT_W-1:0]  tx_count,
   output logic [CNT_W-1:0]  rx_count,
   output logic              fifo_en,
   output logic              wake_en,
   output logic [1:0]        trig_sel,
   output logic              tx_irq,
   output logic              rx_irq
);
   if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 16");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for DEPTH");
   end

   logic             enh_q, rx_flush, tx_flush;
   logic [CNT_W-1:0] cap;

   assign cap = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);

   ufc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .enh_wr(enh_wr), .enh_d(enh_d), .enh_q(enh_q), .fifo_en(fifo_en),
      .wake_en(wake_en), .trig_sel(trig_sel), .rx_flush(rx_flush), .tx_flush(tx_flush)
   );

   ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap(cap),
      .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
      .pop_data(tx_pop_data), .count(tx_count)
   );

   ufc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap(cap),
      .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
      .pop_data(rx_pop_data), .count(rx_count)
   );

   ufc_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
      .tx_flush(tx_flush), .tx_count(tx_count), .rx_count(rx_count),
      .tx_irq(tx_irq), .rx_irq(rx_irq)
   );
endmodule

// File: rtl/ufc_chk.sv
module ufc_chk #(
   parameter int DEPTH = 64,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic [7:0]       host_wdata,
   input logic             enh_q,
   input logic             fifo_en,
   input logic             wake_en,
   input logic [1:0]       trig_sel,
   input logic [CNT_W-1:0] tx_count,
   input logic [CNT_W-1:0] rx_count,
   input logic             tx_irq
);
   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !host_wdata[0] |=> $stable(wake_en) && $stable(trig_sel)); // R1
   AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_wdata[0] && host_wdata[1] |=> rx_count == '0); // R2
   AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_wdata[0] && host_wdata[2] |=> tx_count == '0); // R3
   AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !enh_q |=> $stable(wake_en)); // R4
   AST_EMPTY_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count == '0 |-> tx_irq); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_W'(DEPTH) && rx_count <= CNT_W'(DEPTH)); // R9
   AST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> tx_count <= CNT_W'(1) && rx_count <= CNT_W'(1)); // R11
endmodule

bind uart_fifo_ctrl ufc_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
   .enh_q(enh_q), .fifo_en(fifo_en), .wake_en(wake_en), .trig_sel(trig_sel),
   .tx_count(tx_count), .rx_count(rx_count), .tx_irq(tx_irq)
);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr = 1'b0;
   logic [7:0]        host_wdata = '0;
   logic              enh_wr = 1'b0, enh_d = 1'b0;
   logic              tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [DATA_W-1:0] tx_push_data = '0, rx_push_data = '0;
   logic [DATA_W-1:0] tx_pop_data, rx_pop_data;
   logic [CNT_W-1:0]  tx_count, rx_count;
   logic              fifo_en, wake_en, tx_irq, rx_irq;
   logic [1:0]        trig_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   uart_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
      .enh_wr(enh_wr), .enh_d(enh_d), .tx_push(tx_push), .tx_push_data(tx_push_data),
      .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .rx_push(rx_push),
      .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
      .tx_count(tx_count), .rx_count(rx_count), .fifo_en(fifo_en), .wake_en(wake_en),
      .trig_sel(trig_sel), .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] d);
      host_wr = 1'b1; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic set_gate(input logic b);
      enh_wr = 1'b1; enh_d = b;
      @(negedge clk);
      enh_wr = 1'b0;
   endtask

   task automatic push_tx(input logic [7:0] v);
      tx_push = 1'b1; tx_push_data = v;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pop_tx();
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] v);
      rx_push = 1'b1; rx_push_data = v;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pop_rx();
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 fifo_en reset", int'(fifo_en), 0);
      check("R1 trig_sel reset", int'(trig_sel), 0);
      check("R1 wake_en reset", int'(wake_en), 0);
      check("R8 tx_irq on empty after reset", int'(tx_irq), 1);
      check("R6 rx_irq reset", int'(rx_irq), 0);
   endtask

   task automatic t_fields();
      wr_ctrl(8'hB9);
      check("R4 wake_en gated", int'(wake_en), 0);
      check("R5 select from 7:6 without gate", int'(trig_sel), 2);
      set_gate(1'b1);
      wr_ctrl(8'hB9);
      check("R4 wake_en with gate", int'(wake_en), 1);
      check("R5 select from 5:4 with gate", int'(trig_sel), 3);
      wr_ctrl(8'h38);
      check("R1 enable cleared", int'(fifo_en), 0);
      check("R1 wake_en held", int'(wake_en), 1);
      check("R1 trig_sel held", int'(trig_sel), 3);
      wr_ctrl(8'h01);
      check("R5 select reloaded", int'(trig_sel), 0);
      check("R4 wake_en cleared", int'(wake_en), 0);
      set_gate(1'b0);
      wr_ctrl(8'h09);
      check("R4 bit3 ignored without gate", int'(wake_en), 0);
   endtask

   task automatic t_order();
      wr_ctrl(8'h05);
      for (int i = 0; i < DEPTH; i++) push_tx(8'(i * 3 + 1));
      push_tx(8'hEE);
      check("R9 tx full count", int'(tx_count), DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         pop_tx();
         check("R12 tx order", int'(tx_pop_data), (i * 3 + 1) & 8'hFF);
      end
      pop_tx();
      check("R10 empty pop data held", int'(tx_pop_data), ((DEPTH - 1) * 3 + 1) & 8'hFF);
      check("R10 empty pop count", int'(tx_count), 0);
   endtask

   task automatic t_rx_irq();
      wr_ctrl(8'h81);
      for (int i = 0; i < 13; i++) push_rx(8'(8'h40 + i));
      check("R6 rx below level", int'(rx_irq), 0);
      push_rx(8'h4D);
      check("R6 rx at level", int'(rx_irq), 1);
      push_rx(8'h4E); push_rx(8'h4F); push_rx(8'h99);
      check("R9 rx dropped push", int'(rx_count), DEPTH);
      check("R6 rx above level", int'(rx_irq), 1);
      pop_rx(); check("R12 rx first", int'(rx_pop_data), 8'h40);
      pop_rx(); check("R12 rx second", int'(rx_pop_data), 8'h41);
      pop_rx(); pop_rx();
      check("R6 rx fell below", int'(rx_irq), 0);
      check("R6 rx count", int'(rx_count), 12);
      push_tx(8'h11);
      wr_ctrl(8'h83);
      check("R2 rx flushed", int'(rx_count), 0);
      check("R2 tx untouched", int'(tx_count), 1);
      push_rx(8'h21); push_rx(8'h22); push_rx(8'h23);
      wr_ctrl(8'h81);
      check("R2 no repeat flush", int'(rx_count), 3);
      pop_rx(); check("R12 rx after flush", int'(rx_pop_data), 8'h21);
   endtask

   task automatic t_tx_irq();
      wr_ctrl(8'h45);
      check("R3 tx flushed", int'(tx_count), 0);
      check("R3 rx untouched", int'(rx_count), 2);
      check("R8 tx empty irq", int'(tx_irq), 1);
      push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
      check("R8 partial reload quiet", int'(tx_irq), 0);
      pop_tx(); pop_tx(); pop_tx();
      check("R8 irq on empty", int'(tx_irq), 1);
      for (int i = 0; i < 6; i++) push_tx(8'(i));
      @(negedge clk);
      check("R7 above level quiet", int'(tx_irq), 0);
      pop_tx(); pop_tx();
      check("R7 at level quiet", int'(tx_irq), 0);
      pop_tx();
      check("R7 below level irq", int'(tx_irq), 1);
      pop_tx(); pop_tx(); pop_tx();
      @(negedge clk);
      push_tx(8'hA0); push_tx(8'hA1);
      check("R8 state cleared by empty", int'(tx_irq), 0);
      wr_ctrl(8'h45);
      check("R3 tx flush count", int'(tx_count), 0);
   endtask

   task automatic t_single();
      push_tx(8'h10);
      wr_ctrl(8'h00);
      check("R11 tx flushed on disable", int'(tx_count), 0);
      check("R11 rx flushed on disable", int'(rx_count), 0);
      push_rx(8'h55); push_rx(8'h66);
      check("R11 rx single byte", int'(rx_count), 1);
      check("R11 rx level one", int'(rx_irq), 1);
      push_tx(8'h77); push_tx(8'h78);
      check("R11 tx single byte", int'(tx_count), 1);
      check("R8 tx not empty", int'(tx_irq), 0);
      pop_rx();
      check("R11 rx holding data", int'(rx_pop_data), 8'h55);
   endtask

   initial begin
      #(4 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_order();
      t_rx_irq();
      t_tx_irq();
      t_single();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule